// File: doc/BRIEF.md
# NAND Page Register Read Sequencer

This block sits in front of a NAND flash array whose read path passes through a single page-wide read register. A client issues a read request made of a start byte address and a byte count. The sequencer tracks which page currently sits in the register. It charges the long random page-load latency only when the request falls in a different page. Requests inside the resident page stream out at the short per-byte serial rate. Both latencies are given as cycle counts on configuration inputs.

Requested bytes leave on a valid/ready stream, and the final byte carries a last marker. The sequencer fetches bytes from a synchronous array port that has one cycle of read latency. Two running totals are kept for observation: page loads completed and bytes delivered.

A request is rejected with a one-cycle error pulse when it has zero length or when it reaches past the end of its page. A rejected request changes nothing else.

Top module: `nand_pgreg_seq`

## Requirements
- R1: After reset no page is resident, `req_ready` is 1, `out_valid` is 0, and both totals read 0.
- R2: A legal request whose page index (address divided by 2048, i.e. address bits 17:11) differs from the resident page, or that arrives while no page is resident, performs a page load. Counting the accepting clock edge as edge 0, the first byte becomes valid at edge L+B+3, where L is `cfg_load_cycles` and B is `cfg_byte_cycles`.
- R3: A legal request inside the resident page performs no page load. Its first byte becomes valid at edge B+2 after the accepting edge, and the load total does not change.
- R4: After each output handshake that is not the last one of the request, the next byte becomes valid B+2 edges after the handshake edge. This holds for B = 0 as well.
- R5: Output bytes are the array contents at the start address and the addresses that follow it, in ascending order. `out_last` is 1 exactly on the final byte.
- R6: A request with length 0, or with (address mod 2048) + length > 2048, is accepted and raises `req_err` for the one cycle after the accepting edge. It produces no bytes and leaves the totals and the resident page unchanged.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold. No page load is repeated.
- R8: The load total increments by one when each page load completes. The byte total increments by one on each output handshake.
- R9: Requests that end exactly at the last byte of a page are legal, including a full 2048-byte page. Address 2048·k begins a new page.
- R10: `req_ready` is 1 only while the sequencer is idle. It is 0 throughout a load and while any byte of the current request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_cycles | input | CYC_W | Random page-load latency in cycles |
| cfg_byte_cycles | input | CYC_W | Serial per-byte latency in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | log2(PAGE_BYTES)+1 | Byte count |
| req_err | output | 1 | Rejected-request pulse |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the request |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_addr | output | ADDR_W | Array read byte address |
| arr_rd_data | input | 8 | Array read data, one cycle after the strobe |
| stat_loads | output | STAT_W | Completed page loads |
| stat_bytes | output | STAT_W | Bytes delivered |

## Verification
Two events can land on the same clock edge. The first is the completion of a page load, which commits the new resident page and restarts the byte timer. The second is the final handshake of one request, which is followed at once by the hit-or-load decision for the next request. The bench issues back-to-back requests to a page that has just been loaded, so the next decision has to use the freshly committed page. It also returns to an earlier page, which must load again. It judges each case by the exact first-byte latency: B+2 for a hit and L+B+3 for a load. It also compares the load total with an independent count of expected loads.

// File: rtl/nand_pgreg_pkg.sv
package nand_pgreg_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_SER   = 3'd2,
    S_FETCH = 3'd3,
    S_OUT   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/prs_page_tag.sv
// Resident-page tag and request legality check.
module prs_page_tag #(
  parameter int ADDR_W     = 18,
  parameter int PAGE_BYTES = 2048
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                commit,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
  input  logic [ADDR_W-1:0]                   q_addr,
  input  logic [$clog2(PAGE_BYTES):0]         q_len,
  output logic                                hit,
  output logic                                reject
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam logic [OFF_W+1:0] PG_LIM = (OFF_W+2)'(PAGE_BYTES);

  logic            valid_q;
  logic [PG_W-1:0] tag_q;
  logic [OFF_W+1:0] end_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (commit) begin
      valid_q <= 1'b1;
      tag_q   <= commit_page;
    end
  end

  always_comb begin
    end_pos = {2'b00, q_addr[OFF_W-1:0]} + {1'b0, q_len};
    reject  = (q_len == '0) || (end_pos > PG_LIM);
    hit     = valid_q && (tag_q == q_addr[ADDR_W-1:OFF_W]);
  end
endmodule

// File: rtl/prs_delay_timer.sv
// Down-counting latency timer; done when the count reaches zero.
module prs_delay_timer #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CYC_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (run && cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - CYC_W'(1);
    done   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prs_stat_counters.sv
// Bank of event totals, one per increment strobe.
module prs_stat_counters #(
  parameter int STAT_W = 16,
  parameter int NUM    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM-1:0]        inc,
  output logic [NUM*STAT_W-1:0] counts
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [STAT_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      c_q <= '0;
      else if (inc[g]) c_q <= c_q + STAT_W'(1);
    end
    assign counts[g*STAT_W +: STAT_W] = c_q;
  end
endmodule

// File: rtl/nand_pgreg_seq.sv
module nand_pgreg_seq
  import nand_pgreg_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int PAGE_BYTES = 2048,
  parameter int CYC_W      = 16,
  parameter int STAT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CYC_W-1:0]            cfg_load_cycles,
  input  logic [CYC_W-1:0]            cfg_byte_cycles,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [$clog2(PAGE_BYTES):0] req_len,
  output logic                        req_err,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [7:0]                  out_data,
  output logic                        out_last,
  output logic                        arr_rd_en,
  output logic [ADDR_W-1:0]           arr_rd_addr,
  input  logic [7:0]                  arr_rd_data,
  output logic [STAT_W-1:0]           stat_loads,
  output logic [STAT_W-1:0]           stat_bytes
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int LEN_W = OFF_W + 1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [7:0]        data_q, data_d;
  logic              err_q, err_d;

  logic              tm_load, tm_run, tm_done;
  logic [CYC_W-1:0]  tm_val;
  logic              tag_hit, tag_reject, tag_commit;
  logic              inc_load, inc_byte;
  logic [2*STAT_W-1:0] totals;

  prs_page_tag #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .commit(tag_commit), .commit_page(addr_q[ADDR_W-1:OFF_W]),
    .q_addr(req_addr), .q_len(req_len),
    .hit(tag_hit), .reject(tag_reject)
  );

  prs_delay_timer #(.CYC_W(CYC_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tm_load), .load_val(tm_val), .run(tm_run), .done(tm_done)
  );

  prs_stat_counters #(.STAT_W(STAT_W), .NUM(2)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .inc({inc_byte, inc_load}), .counts(totals)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    rem_d      = rem_q;
    data_d     = data_q;
    err_d      = 1'b0;
    tm_load    = 1'b0;
    tm_val     = cfg_byte_cycles;
    tm_run     = 1'b0;
    tag_commit = 1'b0;
    inc_load   = 1'b0;
    inc_byte   = 1'b0;
    arr_rd_en  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (tag_reject) begin
            err_d = 1'b1;
          end else begin
            addr_d  = req_addr;
            rem_d   = req_len;
            tm_load = 1'b1;
            if (tag_hit) begin
              state_d = S_SER;
              tm_val  = cfg_byte_cycles;
            end else begin
              state_d = S_LOAD;
              tm_val  = cfg_load_cycles;
            end
          end
        end
      end
      S_LOAD: begin
        tm_run = 1'b1;
        if (tm_done) begin
          tag_commit = 1'b1;
          inc_load   = 1'b1;
          tm_load    = 1'b1;
          tm_val     = cfg_byte_cycles;
          state_d    = S_SER;
        end
      end
      S_SER: begin
        tm_run = 1'b1;
        if (tm_done) begin
          arr_rd_en = 1'b1;
          state_d   = S_FETCH;
        end
      end
      S_FETCH: begin
        data_d  = arr_rd_data;
        state_d = S_OUT;
      end
      S_OUT: begin
        if (out_ready) begin
          inc_byte = 1'b1;
          if (rem_q == LEN_W'(1)) begin
            state_d = S_IDLE;
          end else begin
            addr_d  = addr_q + ADDR_W'(1);
            rem_d   = rem_q - LEN_W'(1);
            tm_load = 1'b1;
            tm_val  = cfg_byte_cycles;
            state_d = S_SER;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      data_q  <= data_d;
      err_q   <= err_d;
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign req_err     = err_q;
  assign out_valid   = (state_q == S_OUT);
  assign out_data    = data_q;
  assign out_last    = (state_q == S_OUT) && (rem_q == LEN_W'(1));
  assign arr_rd_addr = addr_q;
  assign stat_loads  = totals[0 +: STAT_W];
  assign stat_bytes  = totals[STAT_W +: STAT_W];
endmodule

// File: rtl/nand_pgreg_seq_checker.sv
module nand_pgreg_seq_checker #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              arr_rd_en,
  input logic [STAT_W-1:0] stat_loads,
  input logic [STAT_W-1:0] stat_bytes
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready); // R10

  AST_HOLD_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_loads - $past(stat_loads)) <= STAT_W'(1)); // R8

  AST_BYTE_ON_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_bytes != $past(stat_bytes)) |-> $past(out_valid && out_ready)); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!out_valid && req_ready)); // R6

  AST_FETCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> !out_valid); // R4
endmodule

bind nand_pgreg_seq nand_pgreg_seq_checker #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .arr_rd_en(arr_rd_en),
  .stat_loads(stat_loads), .stat_bytes(stat_bytes)
);

// File: tb/nand_pgreg_seq_bench.sv
module nand_pgreg_seq_bench;
  localparam int ADDR_W = 18;
  localparam int PB     = 2048;
  localparam int CYC_W  = 16;
  localparam int STAT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [CYC_W-1:0] cfg_load_cycles, cfg_byte_cycles;
  logic req_valid, req_ready, req_err;
  logic [ADDR_W-1:0] req_addr;
  logic [11:0] req_len;
  logic out_valid, out_ready, out_last;
  logic [7:0] out_data;
  logic arr_rd_en;
  logic [ADDR_W-1:0] arr_rd_addr;
  logic [7:0] arr_rd_data;
  logic [STAT_W-1:0] stat_loads, stat_bytes;

  int n_chk = 0, n_bad = 0;
  int exp_loads = 0, exp_bytes = 0;
  int lat_l = 40, lat_b = 3;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  nand_pgreg_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .CYC_W(CYC_W), .STAT_W(STAT_W))
  u_nand_pgreg_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_load_cycles(cfg_load_cycles), .cfg_byte_cycles(cfg_byte_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_err(req_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_rd_data), .stat_loads(stat_loads), .stat_bytes(stat_bytes)
  );

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[15:10], a[17:16]} ^ 8'h5A;
  endfunction

  // Synchronous array stand-in
  always_ff @(posedge clk) begin
    if (arr_rd_en) arr_rd_data <= pat(arr_rd_addr);
  end

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_req(input int addr, input int len, input bit is_hit,
                         input int stall_at, input int stall_n, input string tag);
    int n;
    logic [7:0] held;
    @(negedge clk);
    req_addr = ADDR_W'(addr); req_len = 12'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    n = 0;
    @(posedge clk); n++;
    @(negedge clk); req_valid = 1'b0;
    while (!out_valid && n < 100000) begin @(posedge clk); n++; @(negedge clk); end
    chk({tag, " first-byte latency"}, n, is_hit ? lat_b + 3 : lat_l + lat_b + 4);
    if (!is_hit) exp_loads++;
    chk({tag, " R8 load total"}, stat_loads, exp_loads);
    for (int i = 0; i < len; i++) begin
      chk({tag, " R5 data"}, out_data, pat(ADDR_W'(addr + i)));
      chk({tag, " R5 last"}, out_last, (i == len - 1));
      chk({tag, " R10 ready low while byte pending"}, req_ready, 0);
      if (i == stall_at) begin
        held = out_data;
        for (int s = 0; s < stall_n; s++) begin
          @(negedge clk);
          chk("R7 valid held", out_valid, 1);
          chk("R7 data held", out_data, held);
        end
        chk("R7 no reload", stat_loads, exp_loads);
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk); out_ready = 1'b0;
      exp_bytes++;
      chk({tag, " R8 byte total"}, stat_bytes, exp_bytes);
      if (i < len - 1) begin
        n = 1;
        while (!out_valid && n < 100000) begin @(posedge clk); n++; @(negedge clk); end
        if (i < 3) chk({tag, " R4 inter-byte gap"}, n, lat_b + 3);
      end else begin
        chk({tag, " R10 ready after last"}, req_ready, 1);
        chk({tag, " R5 no extra byte"}, out_valid, 0);
      end
    end
  endtask

  task automatic run_bad(input int addr, input int len);
    @(negedge clk);
    req_addr = ADDR_W'(addr); req_len = 12'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    chk("R6 error pulse", req_err, 1);
    chk("R6 no byte", out_valid, 0);
    @(negedge clk);
    chk("R6 error one cycle", req_err, 0);
    chk("R6 still no byte", out_valid, 0);
    chk("R6 loads unchanged", stat_loads, exp_loads);
    chk("R6 bytes unchanged", stat_bytes, exp_bytes);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
    req_addr = '0; req_len = '0;
    cfg_load_cycles = CYC_W'(lat_l); cfg_byte_cycles = CYC_W'(lat_b);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 loads", stat_loads, 0);
    chk("R1 bytes", stat_bytes, 0);

    run_req(3*PB + 10,   4, 1'b0, -1, 0, "R1 R2 first miss");
    run_req(3*PB + 100,  3, 1'b1, -1, 0, "R3 same page");
    run_bad(3*PB + 2040, 16);
    run_req(3*PB + 2000, 2, 1'b1, -1, 0, "R6 page kept");
    run_bad(3*PB, 0);
    run_req(3*PB + 2047, 1, 1'b1, -1, 0, "R9 last byte");
    run_req(4*PB,        1, 1'b0, -1, 0, "R9 next page");
    run_req(4*PB + 5,    3, 1'b1, 1, 5,  "R7 stall");
    run_req(3*PB,        2, 1'b0, -1, 0, "R2 back to old page");
    lat_b = 0; cfg_byte_cycles = '0;
    run_req(3*PB + 50,   4, 1'b1, -1, 0, "R4 zero byte cost");
    lat_l = 7; cfg_load_cycles = CYC_W'(7);
    run_req(5*PB,        2048, 1'b0, -1, 0, "R9 full page");
    run_req(5*PB + 1024, 2, 1'b1, 0, 2, "R3 after full page");
    finish_up();
  end
endmodule